// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block is the sequencing core of one DMA channel. Software-facing logic elsewhere hands it a base address, a page byte, a base count and a set of mode bits. The block keeps a current address and a current count of its own. Each time a transfer is permitted, it presents the current address, together with the page byte, as a full external address on a registered output. It then steps the address up or down and decrements the count.

The count is programmed as the number of transfers minus one. The transfer made while the current count is zero is the last one: it carries a terminal-count marker and sets a sticky completion flag. After that transfer the channel does one of two things. With auto-initialise set, it reloads both current registers from the base values and stays armed. Without it, the channel masks itself.

Three request disciplines are supported: one transfer per request edge, a burst that runs to terminal count once started, and transfers for as long as the request is held. A parameter builds the channel as a word channel. In that build the address register counts 16-bit words and the emitted byte address is formed by shifting that register left by one, with the upper bits of the page byte above it.

Top module: `dma_chan_engine`

## Requirements
- R1: After synchronous reset, `xfer_vld` and `xfer_tc` are 0, `chan_masked` is 1, `tc_flag` is 0, and the mode is demand, counting up, without auto-initialise.
- R2: A cycle with `wr_base` high loads the base and current address, the base and current count, and the page byte. In a byte channel each transfer presents `xfer_addr = {page, current address}` one cycle after it is granted, with `xfer_vld` high.
- R3: A programmed count of C gives C+1 transfers. The transfer made at count 0 has `xfer_tc` high, and no earlier transfer has it.
- R4: After each transfer the address increments by one, or decrements by one when `mode_down` was 1 at the mode write. It wraps modulo 2^16 without changing the page byte.
- R5: With `mode_auto` = 1, the terminal-count transfer reloads the current address and count from the base values, and the channel stays unmasked.
- R6: With `mode_auto` = 0, the terminal-count transfer sets `chan_masked`, and no further transfer occurs until `mask_clr`.
- R7: `tc_flag` is set by every terminal-count transfer and stays set until `flag_clr`. A set and a clear in the same cycle leave it set.
- R8: With `mode_kind` = 1 (single), exactly one transfer is made per rising edge of `dreq`, however long `dreq` is held.
- R9: With `mode_kind` = 2 (block), a rising edge of `dreq` starts a burst of one transfer per cycle. The burst continues regardless of `dreq` until the terminal-count transfer.
- R10: With `mode_kind` = 0 (demand), one transfer is made in every cycle in which `dreq` is high.
- R11: While `chan_masked` is 1 or `ctl_en` is 0, requests are ignored and the current address and count are held. The next transfer after re-enabling uses the next address in sequence.
- R12: In a word channel (`WORD_CHAN` = 1), `xfer_addr = {page[7:1], current address, 1'b0}`.
- R13: In a cycle with `wr_base` or `mode_we` high, no transfer is granted. A mode write also cancels any running block burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_en | input | 1 | Controller-wide enable |
| wr_base | input | 1 | Load base/current address, count and page |
| wr_addr | input | ADDR_W | Start address (words in a word channel) |
| wr_count | input | CNT_W | Transfers minus one |
| wr_page | input | PAGE_W | Page byte, upper address bits |
| mode_we | input | 1 | Load the mode fields |
| mode_kind | input | 2 | 0 demand, 1 single, 2 block, 3 never transfers |
| mode_auto | input | 1 | Auto-initialise at terminal count |
| mode_down | input | 1 | Decrement the address instead of incrementing |
| mask_set | input | 1 | Mask the channel |
| mask_clr | input | 1 | Unmask the channel |
| flag_clr | input | 1 | Clear the completion flag |
| dreq | input | 1 | Transfer request |
| xfer_vld | output | 1 | A transfer is issued this cycle |
| xfer_addr | output | PAGE_W+ADDR_W | External byte address of the transfer |
| xfer_tc | output | 1 | This transfer is the terminal-count transfer |
| chan_masked | output | 1 | Channel mask state |
| tc_flag | output | 1 | Sticky completion flag |

## Verification
The bench covers the count of zero, which must give exactly one transfer. A design that treats the count as the number of transfers would give none or loop forever. It checks the down-counting wrap from 0x0000 to 0xFFFF, which must not disturb the page byte. In the word build it checks that address bit 16 comes from the address register. It confirms that a held request in single mode gives one transfer and not one per cycle, and that a block burst outlives its request and ends at terminal count. It also covers masking and disabling between transfers, where a faulty design would either lose an address step or issue a transfer anyway. Finally it checks that configuration writes suppress the transfer in their own cycle, that a mode write cancels a block burst, and that the auto-reload restarts from the base address.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  typedef enum logic [1:0] {
    XK_DEMAND  = 2'd0,
    XK_SINGLE  = 2'd1,
    XK_BLOCK   = 2'd2,
    XK_CASCADE = 2'd3
  } xfer_kind_e;

  typedef struct packed {
    xfer_kind_e kind;
    logic       autoinit;
    logic       down;
  } chan_mode_t;
endpackage

// File: rtl/dma_req_gate.sv
module dma_req_gate
  import dma_eng_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       dreq,
  input  logic       permit,
  input  xfer_kind_e kind,
  input  logic       last,
  input  logic       cancel,
  output logic       go
);
  logic dreq_q;
  logic burst_q;
  logic rise;

  assign rise = dreq & ~dreq_q;

  always_comb begin
    unique case (kind)
      XK_DEMAND: go = permit & dreq;
      XK_SINGLE: go = permit & rise;
      XK_BLOCK:  go = permit & (burst_q | rise);
      default:   go = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dreq_q  <= 1'b0;
      burst_q <= 1'b0;
    end else begin
      dreq_q <= dreq;
      if (cancel)
        burst_q <= 1'b0;
      else if (go)
        burst_q <= (kind == XK_BLOCK) & ~last;
    end
  end
endmodule

// File: rtl/dma_addr_cnt.sv
module dma_addr_cnt #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [CNT_W-1:0]  ld_cnt,
  input  logic              step,
  input  logic              down,
  input  logic              autoinit,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              last
);
  localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  C_ONE = CNT_W'(1);

  logic [ADDR_W-1:0] base_addr;
  logic [CNT_W-1:0]  base_cnt;
  logic [CNT_W-1:0]  cur_cnt;

  assign last = (cur_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
    end else if (load) begin
      base_addr <= ld_addr;
      base_cnt  <= ld_cnt;
      cur_addr  <= ld_addr;
      cur_cnt   <= ld_cnt;
    end else if (step) begin
      if (last && autoinit) begin
        cur_addr <= base_addr;
        cur_cnt  <= base_cnt;
      end else begin
        cur_addr <= down ? cur_addr - A_ONE : cur_addr + A_ONE;
        cur_cnt  <= cur_cnt - C_ONE;
      end
    end
  end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_eng_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 16,
  parameter int PAGE_W    = 8,
  parameter bit WORD_CHAN = 1'b0,
  localparam int OUT_W    = PAGE_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_en,
  input  logic              wr_base,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_count,
  input  logic [PAGE_W-1:0] wr_page,
  input  logic              mode_we,
  input  logic [1:0]        mode_kind,
  input  logic              mode_auto,
  input  logic              mode_down,
  input  logic              mask_set,
  input  logic              mask_clr,
  input  logic              flag_clr,
  input  logic              dreq,
  output logic              xfer_vld,
  output logic [OUT_W-1:0]  xfer_addr,
  output logic              xfer_tc,
  output logic              chan_masked,
  output logic              tc_flag
);
  chan_mode_t        mode_q;
  logic [PAGE_W-1:0] page_q;
  logic [ADDR_W-1:0] cur_addr;
  logic [OUT_W-1:0]  ext_addr;
  logic              last;
  logic              go;
  logic              permit;

  assign permit = ctl_en & ~chan_masked & ~wr_base & ~mode_we;

  dma_req_gate u_gate (
    .clk    (clk),
    .rst    (rst),
    .dreq   (dreq),
    .permit (permit),
    .kind   (mode_q.kind),
    .last   (last),
    .cancel (mode_we),
    .go     (go)
  );

  dma_addr_cnt #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (wr_base),
    .ld_addr  (wr_addr),
    .ld_cnt   (wr_count),
    .step     (go),
    .down     (mode_q.down),
    .autoinit (mode_q.autoinit),
    .cur_addr (cur_addr),
    .last     (last)
  );

  generate
    if (WORD_CHAN) begin : g_word
      assign ext_addr = {page_q[PAGE_W-1:1], cur_addr, 1'b0};
    end else begin : g_byte
      assign ext_addr = {page_q, cur_addr};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= '0;
      page_q      <= '0;
      chan_masked <= 1'b1;
      tc_flag     <= 1'b0;
      xfer_vld    <= 1'b0;
      xfer_tc     <= 1'b0;
      xfer_addr   <= '0;
    end else begin
      if (mode_we)
        mode_q <= '{kind: xfer_kind_e'(mode_kind), autoinit: mode_auto, down: mode_down};
      if (wr_base)
        page_q <= wr_page;
      if (go && last && !mode_q.autoinit)
        chan_masked <= 1'b1;
      else if (mask_set)
        chan_masked <= 1'b1;
      else if (mask_clr)
        chan_masked <= 1'b0;
      if (go && last)
        tc_flag <= 1'b1;
      else if (flag_clr)
        tc_flag <= 1'b0;
      xfer_vld <= go;
      xfer_tc  <= go & last;
      if (go)
        xfer_addr <= ext_addr;
    end
  end
endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk #(
  parameter bit WORD_CHAN = 1'b0
) (
  input logic clk,
  input logic rst,
  input logic ctl_en,
  input logic xfer_vld,
  input logic xfer_tc,
  input logic addr_lsb,
  input logic masked,
  input logic tc_flag,
  input logic mode_auto
);
  // R3: terminal count only accompanies a transfer
  a_r3_tc_needs_xfer: assert property (@(posedge clk) disable iff (rst)
    xfer_tc |-> xfer_vld);

  // R7: a terminal-count transfer leaves the flag set
  a_r7_flag_on_tc: assert property (@(posedge clk) disable iff (rst)
    xfer_tc |-> tc_flag);

  // R6: no auto-initialise means the channel masks itself at terminal count
  a_r6_mask_on_tc: assert property (@(posedge clk) disable iff (rst)
    (xfer_tc && !mode_auto) |-> masked);

  // R11: a masked channel issues nothing in the next cycle
  a_r11_mask_blocks: assert property (@(posedge clk) disable iff (rst)
    masked |=> !xfer_vld);

  // R11: a disabled controller issues nothing in the next cycle
  a_r11_disable_blocks: assert property (@(posedge clk) disable iff (rst)
    !ctl_en |=> !xfer_vld);

  // R12: word channels emit even byte addresses
  a_r12_word_even: assert property (@(posedge clk) disable iff (rst)
    (xfer_vld && WORD_CHAN) |-> !addr_lsb);
endmodule

bind dma_chan_engine dma_chan_engine_chk #(.WORD_CHAN(WORD_CHAN)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ctl_en    (ctl_en),
  .xfer_vld  (xfer_vld),
  .xfer_tc   (xfer_tc),
  .addr_lsb  (xfer_addr[0]),
  .masked    (chan_masked),
  .tc_flag   (tc_flag),
  .mode_auto (mode_q.autoinit)
);

// File: tb/tb_dma_chan_engine.sv
module tb_dma_chan_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_en = 1'b0;
  logic        wr_base = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [15:0] wr_count = '0;
  logic [7:0]  wr_page = '0;
  logic        mode_we = 1'b0;
  logic [1:0]  mode_kind = '0;
  logic        mode_auto = 1'b0;
  logic        mode_down = 1'b0;
  logic        mask_set = 1'b0;
  logic        mask_clr = 1'b0;
  logic        flag_clr = 1'b0;
  logic        dreq = 1'b0;

  logic        xfer_vld, xfer_tc, chan_masked, tc_flag;
  logic [23:0] xfer_addr;
  logic        w_vld, w_tc, w_masked, w_flag;
  logic [23:0] w_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dma_chan_engine dut (
    .clk(clk), .rst(rst), .ctl_en(ctl_en), .wr_base(wr_base), .wr_addr(wr_addr),
    .wr_count(wr_count), .wr_page(wr_page), .mode_we(mode_we), .mode_kind(mode_kind),
    .mode_auto(mode_auto), .mode_down(mode_down), .mask_set(mask_set),
    .mask_clr(mask_clr), .flag_clr(flag_clr), .dreq(dreq), .xfer_vld(xfer_vld),
    .xfer_addr(xfer_addr), .xfer_tc(xfer_tc), .chan_masked(chan_masked), .tc_flag(tc_flag)
  );

  dma_chan_engine #(.WORD_CHAN(1'b1)) dut_w (
    .clk(clk), .rst(rst), .ctl_en(ctl_en), .wr_base(wr_base), .wr_addr(wr_addr),
    .wr_count(wr_count), .wr_page(wr_page), .mode_we(mode_we), .mode_kind(mode_kind),
    .mode_auto(mode_auto), .mode_down(mode_down), .mask_set(mask_set),
    .mask_clr(mask_clr), .flag_clr(flag_clr), .dreq(dreq), .xfer_vld(w_vld),
    .xfer_addr(w_addr), .xfer_tc(w_tc), .chan_masked(w_masked), .tc_flag(w_flag)
  );

  // {dreq, exp_vld, exp_tc, exp_addr[23:0]}; demand, auto, base 0x561234, count 2
  localparam logic [26:0] VEC [6] = '{
    {1'b1, 1'b1, 1'b0, 24'h561234},
    {1'b0, 1'b0, 1'b0, 24'h000000},
    {1'b1, 1'b1, 1'b0, 24'h561235},
    {1'b1, 1'b1, 1'b1, 24'h561236},
    {1'b1, 1'b1, 1'b0, 24'h561234},
    {1'b0, 1'b0, 1'b0, 24'h000000}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic load_base(input logic [7:0] pg, input logic [15:0] a, input logic [15:0] c);
    wr_base = 1'b1; wr_page = pg; wr_addr = a; wr_count = c;
    tick();
    wr_base = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] k, input logic au, input logic dn);
    mode_we = 1'b1; mode_kind = k; mode_auto = au; mode_down = dn;
    tick();
    mode_we = 1'b0;
  endtask

  task automatic unmask();
    mask_clr = 1'b1;
    tick();
    mask_clr = 1'b0;
  endtask

  task automatic expect_xfer(input string req, input logic [23:0] a, input logic tc);
    check(req, {31'd0, xfer_vld}, 32'd1);
    check(req, {8'd0, xfer_addr}, {8'd0, a});
    check(req, {31'd0, xfer_tc}, {31'd0, tc});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    rst = 1'b0;
    // R1 reset state
    check("R1 vld", {31'd0, xfer_vld}, 32'd0);
    check("R1 tc", {31'd0, xfer_tc}, 32'd0);
    check("R1 masked", {31'd0, chan_masked}, 32'd1);
    check("R1 flag", {31'd0, tc_flag}, 32'd0);

    load_base(8'h56, 16'h1234, 16'd2);
    set_mode(2'd0, 1'b1, 1'b0);
    unmask();
    ctl_en = 1'b1;

    // R2 R3 R5 R10: vector walk in demand mode with auto-initialise
    for (int i = 0; i < 6; i++) begin
      dreq = VEC[i][26];
      tick();
      check("R10 vld", {31'd0, xfer_vld}, {31'd0, VEC[i][25]});
      if (VEC[i][25]) begin
        check("R2 addr", {8'd0, xfer_addr}, {8'd0, VEC[i][23:0]});
        check("R3 tc", {31'd0, xfer_tc}, {31'd0, VEC[i][24]});
        check("R5 unmasked", {31'd0, chan_masked}, 32'd0);
      end
      if (i == 0)
        check("R12 word addr", {8'd0, w_addr}, 32'h00562468);
    end

    // R11 masked channel ignores requests and holds its position
    mask_set = 1'b1; tick(); mask_set = 1'b0;
    dreq = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R11 masked no xfer", {31'd0, xfer_vld}, 32'd0);
    end
    dreq = 1'b0;
    unmask();
    dreq = 1'b1; tick();
    expect_xfer("R11 resume addr", 24'h561235, 1'b0);
    ctl_en = 1'b0;
    tick(); tick();
    check("R11 disabled no xfer", {31'd0, xfer_vld}, 32'd0);
    ctl_en = 1'b1;
    tick();
    expect_xfer("R11 resume after enable", 24'h561236, 1'b1);
    dreq = 1'b0; tick();

    // R7 flag clear; R3 count 0 gives one transfer; R6 self-mask
    check("R7 flag sticky", {31'd0, tc_flag}, 32'd1);
    flag_clr = 1'b1; tick(); flag_clr = 1'b0;
    check("R7 flag cleared", {31'd0, tc_flag}, 32'd0);
    load_base(8'h12, 16'h00FF, 16'd0);
    set_mode(2'd0, 1'b0, 1'b0);
    dreq = 1'b1; tick();
    expect_xfer("R3 single transfer at count 0", 24'h1200FF, 1'b1);
    check("R6 masked at tc", {31'd0, chan_masked}, 32'd1);
    check("R7 flag set", {31'd0, tc_flag}, 32'd1);
    tick();
    check("R6 no xfer after tc", {31'd0, xfer_vld}, 32'd0);
    dreq = 1'b0; tick();

    // R4 down-count wrap without page change; R12 bit 16 from address
    load_base(8'h12, 16'h0001, 16'd2);
    set_mode(2'd0, 1'b0, 1'b1);
    unmask();
    dreq = 1'b1; tick();
    expect_xfer("R4 down 1", 24'h120001, 1'b0);
    tick();
    expect_xfer("R4 down 2", 24'h120000, 1'b0);
    tick();
    expect_xfer("R4 wrap", 24'h12FFFF, 1'b1);
    check("R12 word wrap addr", {8'd0, w_addr}, 32'h0013FFFE);
    dreq = 1'b0; tick();

    // R8 single mode: held request gives one transfer
    load_base(8'h12, 16'h0100, 16'd3);
    set_mode(2'd1, 1'b1, 1'b0);
    unmask();
    dreq = 1'b1; tick();
    expect_xfer("R8 first", 24'h120100, 1'b0);
    tick();
    check("R8 held no repeat", {31'd0, xfer_vld}, 32'd0);
    tick();
    check("R8 held no repeat", {31'd0, xfer_vld}, 32'd0);
    dreq = 1'b0; tick();
    dreq = 1'b1; tick();
    expect_xfer("R8 second edge", 24'h120101, 1'b0);
    dreq = 1'b0; tick();

    // R9 block mode: burst runs without request until tc
    load_base(8'h12, 16'h0200, 16'd2);
    set_mode(2'd2, 1'b0, 1'b0);
    dreq = 1'b1; tick();
    expect_xfer("R9 start", 24'h120200, 1'b0);
    dreq = 1'b0; tick();
    expect_xfer("R9 continue", 24'h120201, 1'b0);
    tick();
    expect_xfer("R9 end", 24'h120202, 1'b1);
    tick();
    check("R9 stopped", {31'd0, xfer_vld}, 32'd0);

    // R13 mode write cancels a burst
    load_base(8'h12, 16'h0300, 16'd5);
    set_mode(2'd2, 1'b1, 1'b0);
    unmask();
    dreq = 1'b1; tick();
    expect_xfer("R13 burst start", 24'h120300, 1'b0);
    dreq = 1'b0;
    mode_we = 1'b1; tick(); mode_we = 1'b0;
    check("R13 mode write suppresses", {31'd0, xfer_vld}, 32'd0);
    tick();
    check("R13 burst cancelled", {31'd0, xfer_vld}, 32'd0);

    // R13 base write suppresses a transfer in its cycle
    set_mode(2'd0, 1'b1, 1'b0);
    dreq = 1'b1;
    wr_base = 1'b1; wr_page = 8'h12; wr_addr = 16'h0400; wr_count = 16'd1;
    tick();
    wr_base = 1'b0;
    check("R13 base write suppresses", {31'd0, xfer_vld}, 32'd0);
    tick();
    expect_xfer("R13 new base used", 24'h120400, 1'b0);
    dreq = 1'b0; tick();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule